// File: doc/BRIEF.md
# Audio Sample Buffer Controller

This block holds a 2 KB byte buffer of audio samples together with a small bank of byte-wide control registers. A host reaches both over a simple byte bus with one address, separate read and write strobes, and read data that arrives one cycle after the request, marked by a valid strobe.

The buffer is addressed in one of two ways, chosen by the mode register. In the off and wavetable modes, and in the spare mode value 3, the host reads and writes any byte directly at the bus address. In PCM mode the buffer becomes an append-only queue and the bus address inside the buffer window no longer picks the byte. With mono selected, one pointer walks the whole buffer. With stereo selected, the buffer splits into a left half and a right half, each with its own pointer. Each write stores at the current pointer and then advances that pointer. Reads return the byte that the right or mono pointer currently designates.

The register window sits directly above the buffer, at byte offsets 0x800 to 0x807. The pointers are 16 bits wide and are only seen through PCM-mode reads.

Top module: `sample_buf_ctrl`

## Requirements
- R1: After reset every register in 0x800..0x807 reads 0x00, except 0x804, which reads 0xFF. Both sample pointers start at 0.
- R2: A read request in cycle N gives rd_valid high in cycle N+1 with the data. rd_valid is low in every cycle that does not follow a read request.
- R3: Offset 0x800 always reads 0x00 and offset 0x804 always reads 0xFF. Writes to either offset have no effect.
- R4: Offset 0x801 is the mode register. It keeps bits 1:0 of a write and reads back with bits 7:2 at zero. Value 1 selects PCM. Values 0, 2 and 3 select random access.
- R5: Offsets 0x802, 0x803, 0x805, 0x806 and 0x807 read back the full byte last written to them. Bit 1 of 0x802 selects stereo (1) or mono (0) for PCM.
- R6: In random-access mode a buffer access at bus address A (A below 0x800) reads or writes byte A. Such accesses leave both pointers unchanged.
- R7: In mono PCM, a write to any buffer address stores at the left pointer modulo 0x800 and then increments the left pointer.
- R8: In stereo PCM, a write to an address below 0x400 stores at the left pointer modulo 0x400 and then increments the left pointer.
- R9: In stereo PCM, a write to an address from 0x400 to 0x7FF stores at 0x400 plus the right pointer modulo 0x400 and then increments the right pointer.
- R10: In PCM mode a buffer read returns, whatever the bus address, the byte at 0x400 plus the right pointer modulo 0x400 when stereo, or the byte at the left pointer modulo 0x800 when mono. Reads do not move either pointer.
- R11: A pointer that passes the end of its region wraps, so that the next write lands at the start of that region again.
- R12: Addresses 0x808 to 0xFFF read 0x00. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address: buffer at 0x000-0x7FF, registers at 0x800-0x807 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
The assertions watch on every cycle that the read latency is one cycle, and that each kind of buffer write advances exactly the right pointer by one or leaves both pointers alone. They also check that a stereo left-half write lands in the lower half, and that reads of the version and mode registers and of the unmapped hole return their fixed bits. Only the bench's scenarios can show where the bytes actually go and which byte a PCM read returns. These scenarios include the interleaving of random-access and PCM phases, the switch between mono and stereo with pointers already advanced, and wrap-around after more than a full buffer of appends. They check all of this against a byte-level model of the buffer.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_PCM   = 2'd1,
    MODE_WAVE  = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUF  = 2'd1,
    SRC_REG  = 2'd2
  } rd_src_e;

  localparam logic [2:0] OFF_VER   = 3'd0;
  localparam logic [2:0] OFF_MODE  = 3'd1;
  localparam logic [2:0] OFF_CHAN  = 3'd2;
  localparam logic [2:0] OFF_FIFO  = 3'd3;
  localparam logic [2:0] OFF_FLAG  = 3'd4;
  localparam logic [2:0] OFF_AUX   = 3'd5;
  localparam logic [2:0] OFF_VOL   = 3'd6;
  localparam logic [2:0] OFF_RATE  = 3'd7;

  localparam logic [7:0] VER_VALUE  = 8'h00;
  localparam logic [7:0] FLAG_VALUE = 8'hFF;
endpackage

// File: rtl/sbc_regs.sv
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    off,
  input  logic [DW-1:0] wdata,
  output mode_e         mode,
  output logic          stereo,
  output logic [DW-1:0] rdata_q
);
  logic [1:0]    mode_q;
  logic [DW-1:0] chan_q, fifo_q, aux_q, vol_q, rate_q;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      chan_q <= '0;
      fifo_q <= '0;
      aux_q  <= '0;
      vol_q  <= '0;
      rate_q <= '0;
    end else if (wr_en) begin
      case (off)
        OFF_MODE: mode_q <= wdata[1:0];
        OFF_CHAN: chan_q <= wdata;
        OFF_FIFO: fifo_q <= wdata;
        OFF_AUX:  aux_q  <= wdata;
        OFF_VOL:  vol_q  <= wdata;
        OFF_RATE: rate_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off)
      OFF_VER:  rd_mux = DW'(VER_VALUE);
      OFF_MODE: rd_mux = DW'(mode_q);
      OFF_CHAN: rd_mux = chan_q;
      OFF_FIFO: rd_mux = fifo_q;
      OFF_FLAG: rd_mux = DW'(FLAG_VALUE);
      OFF_AUX:  rd_mux = aux_q;
      OFF_VOL:  rd_mux = vol_q;
      default:  rd_mux = rate_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign mode   = mode_e'(mode_q);
  assign stereo = chan_q[1];

  p_ver_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == OFF_VER) |=> (rdata_q == DW'(VER_VALUE)));
  p_flag_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == OFF_FLAG) |=> (rdata_q == DW'(FLAG_VALUE)));
  p_mode_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == OFF_MODE) |=> (rdata_q[DW-1:2] == '0));
endmodule

// File: rtl/sbc_ptrs.sv
module sbc_ptrs
  import sbc_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_buf,
  input  logic [AW-1:0] addr,
  input  mode_e         mode,
  input  logic          stereo,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx
);
  localparam logic [PW-1:0] STEP = PW'(1);

  logic [PW-1:0] lp_q, rp_q;
  logic          pcm, upper;
  logic          bump_left, bump_right;

  function automatic logic [AW-1:0] f_mono(input logic [PW-1:0] p);
    return p[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] f_half(input logic hi, input logic [PW-1:0] p);
    return {hi, p[AW-2:0]};
  endfunction

  assign pcm   = (mode == MODE_PCM);
  assign upper = addr[AW-1];

  assign bump_left  = wr_buf && pcm && !(stereo && upper);
  assign bump_right = wr_buf && pcm && stereo && upper;

  always_comb begin
    if (!pcm)           wr_idx = addr;
    else if (!stereo)   wr_idx = f_mono(lp_q);
    else if (upper)     wr_idx = f_half(1'b1, rp_q);
    else                wr_idx = f_half(1'b0, lp_q);
  end

  always_comb begin
    if (!pcm)         rd_idx = addr;
    else if (stereo)  rd_idx = f_half(1'b1, rp_q);
    else              rd_idx = f_mono(lp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q <= '0;
      rp_q <= '0;
    end else begin
      if (bump_left)  lp_q <= lp_q + STEP;
      if (bump_right) rp_q <= rp_q + STEP;
    end
  end

  p_hold_random_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PCM) |=> ($stable(lp_q) && $stable(rp_q)));
  p_mono_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && mode == MODE_PCM && !stereo) |=> (lp_q == $past(lp_q) + STEP && $stable(rp_q)));
  p_left_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && mode == MODE_PCM && stereo && !addr[AW-1]) |=> (lp_q == $past(lp_q) + STEP && $stable(rp_q)));
  p_left_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && mode == MODE_PCM && stereo && !addr[AW-1]) |-> !wr_idx[AW-1]);
  p_right_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && mode == MODE_PCM && stereo && addr[AW-1]) |=> (rp_q == $past(rp_q) + STEP && $stable(lp_q)));
  p_right_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && mode == MODE_PCM && stereo && addr[AW-1]) |-> wr_idx[AW-1]);
  p_read_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_buf) |=> ($stable(lp_q) && $stable(rp_q)));
endmodule

// File: rtl/sbc_store.sv
module sbc_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[ridx];
  end
endmodule

// File: rtl/sample_buf_ctrl.sv
module sample_buf_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUF_AW = 11,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int REG_AW = 3;
  localparam int HI_W   = ADDR_W - BUF_AW;

  logic          in_buf, in_reg;
  mode_e         mode;
  logic          stereo;
  logic [BUF_AW-1:0] wr_idx, rd_idx;
  logic [DATA_W-1:0] mem_q, reg_q;
  rd_src_e       src_q;
  logic          valid_q;

  assign in_buf = (bus_addr[ADDR_W-1:BUF_AW] == '0);
  assign in_reg = (bus_addr[ADDR_W-1:BUF_AW] == HI_W'(1)) &&
                  (bus_addr[BUF_AW-1:REG_AW] == '0);

  sbc_regs #(.DW(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr && in_reg),
    .rd_en  (bus_rd && in_reg),
    .off    (bus_addr[REG_AW-1:0]),
    .wdata  (bus_wdata),
    .mode   (mode),
    .stereo (stereo),
    .rdata_q(reg_q)
  );

  sbc_ptrs #(.AW(BUF_AW), .PW(PTR_W)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_buf(bus_wr && in_buf),
    .addr  (bus_addr[BUF_AW-1:0]),
    .mode  (mode),
    .stereo(stereo),
    .wr_idx(wr_idx),
    .rd_idx(rd_idx)
  );

  sbc_store #(.AW(BUF_AW), .DW(DATA_W)) u_store (
    .clk  (clk),
    .we   (bus_wr && in_buf),
    .widx (wr_idx),
    .wdata(bus_wdata),
    .re   (bus_rd && in_buf),
    .ridx (rd_idx),
    .q    (mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
    end else begin
      valid_q <= bus_rd;
      if (bus_rd) src_q <= in_buf ? SRC_BUF : (in_reg ? SRC_REG : SRC_NONE);
    end
  end

  always_comb begin
    case (src_q)
      SRC_BUF: rd_data = mem_q;
      SRC_REG: rd_data = reg_q;
      default: rd_data = '0;
    endcase
  end

  assign rd_valid = valid_q;

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);
  p_hole_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_buf && !in_reg) |=> (rd_data == '0));
endmodule

// File: tb/sample_buf_ctrl_test.sv
module sample_buf_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  // bench-side model
  logic [7:0]  m [0:2047];
  logic [15:0] lp = '0, rp = '0;
  logic [1:0]  m_mode = '0;
  logic [7:0]  m_chan = '0, m_fifo = '0, m_aux = '0, m_vol = '0, m_rate = '0;

  always #5 clk = ~clk;

  sample_buf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] model_read(input logic [11:0] a);
    if (a < 12'h800) begin
      if (m_mode == 2'd1) begin
        if (m_chan[1]) return m[11'h400 + {1'b0, rp[9:0]}];
        return m[lp[10:0]];
      end
      return m[a[10:0]];
    end
    case (a)
      12'h800: return 8'h00;
      12'h801: return {6'b0, m_mode};
      12'h802: return m_chan;
      12'h803: return m_fifo;
      12'h804: return 8'hFF;
      12'h805: return m_aux;
      12'h806: return m_vol;
      12'h807: return m_rate;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [7:0] d);
    if (a < 12'h800) begin
      if (m_mode == 2'd1) begin
        if (!m_chan[1]) begin m[lp[10:0]] = d; lp = lp + 16'd1; end
        else if (a < 12'h400) begin m[{1'b0, lp[9:0]}] = d; lp = lp + 16'd1; end
        else begin m[{1'b1, rp[9:0]}] = d; rp = rp + 16'd1; end
      end else m[a[10:0]] = d;
    end else begin
      case (a)
        12'h801: m_mode = d[1:0];
        12'h802: m_chan = d;
        12'h803: m_fifo = d;
        12'h805: m_aux = d;
        12'h806: m_vol = d;
        12'h807: m_rate = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    model_write(a, d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compares results as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: rd_valid without request, actual %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: reset state of the register window
    for (int i = 0; i < 8; i++) rd(12'h800 + 12'(i), "R1");

    // R5: plain registers hold the full byte
    wr(12'h803, 8'hA5); wr(12'h805, 8'h3C); wr(12'h806, 8'h7E);
    wr(12'h807, 8'hC3); wr(12'h802, 8'hF0);
    rd(12'h803, "R5"); rd(12'h805, "R5"); rd(12'h806, "R5");
    rd(12'h807, "R5"); rd(12'h802, "R5");
    wr(12'h802, 8'h00);

    // R4: mode keeps two bits
    wr(12'h801, 8'hFE); rd(12'h801, "R4");
    wr(12'h801, 8'h00);

    // R3: fixed registers ignore writes
    wr(12'h800, 8'h55); rd(12'h800, "R3");
    wr(12'h804, 8'h00); rd(12'h804, "R3");

    // R6: random-access fill and readback
    for (int i = 0; i < 2048; i++) wr(12'(i), 8'(i * 7 + 3));
    rd(12'h000, "R6"); rd(12'h3FF, "R6"); rd(12'h400, "R6"); rd(12'h7FF, "R6");
    wr(12'h801, 8'h02);
    wr(12'h123, 8'h99); rd(12'h123, "R6");
    wr(12'h801, 8'h03);
    wr(12'h055, 8'h5A); rd(12'h055, "R4");

    // R12: hole above the register window
    wr(12'h900, 8'h11); rd(12'h900, "R12"); rd(12'hFFF, "R12"); rd(12'h808, "R12");
    rd(12'h100, "R12");

    // R7 / R10: mono PCM
    wr(12'h801, 8'h01);
    rd(12'h777, "R10");
    wr(12'h700, 8'hE1); wr(12'h010, 8'hE2); wr(12'h3FF, 8'hE3);
    rd(12'h000, "R10"); rd(12'h600, "R10");
    wr(12'h801, 8'h00);
    rd(12'h000, "R7"); rd(12'h001, "R7"); rd(12'h002, "R7");

    // R8 / R9 / R10: stereo PCM
    wr(12'h801, 8'h01); wr(12'h802, 8'h02);
    rd(12'h020, "R10");
    wr(12'h020, 8'hB1);
    wr(12'h400, 8'hB2);
    wr(12'h7FF, 8'hB3);
    rd(12'h001, "R10");
    wr(12'h801, 8'h00);
    rd(12'h003, "R8"); rd(12'h400, "R9"); rd(12'h401, "R9"); rd(12'h020, "R8");

    // R11: mono pointer wraps past the end of the buffer
    wr(12'h801, 8'h01); wr(12'h802, 8'h00);
    for (int i = 0; i < 2045; i++) wr(12'(i & 12'h7FF), 8'(i * 5 + 1));
    rd(12'h000, "R11");
    wr(12'h801, 8'h00);
    rd(12'h000, "R11"); rd(12'h7FF, "R11");

    // R11 / R8: stereo halves wrap within their 1 KB regions
    wr(12'h801, 8'h01); wr(12'h802, 8'h02);
    for (int i = 0; i < 1030; i++) wr(12'h400, 8'(i ^ 8'h6C));
    rd(12'h000, "R11");
    wr(12'h010, 8'hD7);
    wr(12'h801, 8'h00);
    rd(12'h401, "R11"); rd(12'h406, "R11"); rd(12'h405, "R11"); rd(12'h002, "R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: actual %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule